// File: doc/BRIEF.md
# Interleaved Multi-Bank Memory Controller

This block stores 32-bit words across four independent synchronous banks held inside it and serves one read or write request per cycle. Each request carries a 28-bit byte address. The block splits that address into three parts: a byte offset, a bank index and a word address inside the bank. It then sends the request to the selected bank. After any access a bank needs a fixed recovery time before it can take another one. A request that targets a recovering bank is held off by deasserting ready, and every such stalled cycle is counted.

A run-time select picks one of two bank mappings. The plain mapping takes the bank directly from the low word-address bits, so sequential words rotate through all banks. The hashed mapping XORs those bits with two higher address bits. Addresses that share a cache set, and therefore share their low bits, then land on different banks. Read data returns one cycle after acceptance, which keeps responses in request order.

Top module: `bank_interleave_ctrl`

## Requirements
- R1: After reset, no response is valid, the conflict count is 0, and `req_ready_o` is 1 for every bank.
- R2: Address bits [1:0] are a byte offset and do not change which word is accessed. In plain mode the bank is address bits [3:2], so 0x1A35C7B goes to bank 2. The word address is bits [27:4], and each bank stores 64 words indexed by the low 6 bits of the word address, so word addresses that differ only above bit 5 alias.
- R3: A bank accepted at clock edge t refuses requests (`req_ready_o` low while it is targeted) until edge t+RECOVERY, where RECOVERY defaults to 3. A request to a different, idle bank is accepted at once.
- R4: `conflict_cnt_o` increments by one on every clock edge at which `req_valid_i` is high and `req_ready_o` is low.
- R5: With RECOVERY no larger than the bank count, back-to-back stride-1 word requests are never stalled.
- R6: In plain mode, back-to-back requests with a 16-byte stride (4 words) hit one bank, and each request after the first stalls RECOVERY-1 cycles.
- R7: An accepted read raises `rsp_valid_o` for exactly one cycle, on the edge after acceptance, with the word most recently written to that location. A write produces no response.
- R8: When `xor_mode_i` is 1, the bank is address bits [3:2] XOR bits [13:12]. A 4096-byte stride then rotates across banks with no stalls, while the same stream in plain mode stalls RECOVERY-1 cycles per request.
- R9: Data written in hashed mode reads back intact in hashed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xor_mode_i | input | 1 | 1 selects hashed bank mapping, 0 selects plain mapping |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | The target bank can accept the request this cycle |
| req_we_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | 28 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | 32 | Read data |
| conflict_cnt_o | output | 16 | Count of stalled request cycles |

## Verification
The bench places a request on bank 2 right after another access to bank 2, and separately right after an access to another bank. A recovery counter loaded one value off would show up as a stall count of 1 or 3 instead of 2, or as a stall on an idle bank. It writes through the example address and reads back through an alias that has a different high word address and a different byte offset. A wrong field split or a wrong bank index would return stale data. It runs strides of 1 word, 4 words and 4096 bytes in both modes. A hash that used the wrong bits, or that leaked into plain mode, would change which streams stall. Counting stall cycles against the conflict counter catches a counter that ticks once per request instead of once per cycle.

// File: rtl/bank_ilv_pkg.sv
package bank_ilv_pkg;
  typedef enum logic {
    MAP_PLAIN = 1'b0,
    MAP_XOR   = 1'b1
  } map_mode_e;
endpackage

// File: rtl/bank_addr_map.sv
module bank_addr_map #(
  parameter int unsigned ADDR_W     = 28,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned HASH_LSB   = 12,
  localparam int unsigned OFF_W     = $clog2(WORD_BYTES),
  localparam int unsigned BANK_W    = $clog2(NUM_BANKS),
  localparam int unsigned WADDR_W   = ADDR_W - OFF_W - BANK_W
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  bank_ilv_pkg::map_mode_e  mode_i,
  output logic [BANK_W-1:0]        bank_o,
  output logic [WADDR_W-1:0]       waddr_o
);
  logic [BANK_W-1:0] low_bits, tag_bits;
  logic              unused_off;

  assign low_bits   = addr_i[OFF_W +: BANK_W];
  assign tag_bits   = addr_i[HASH_LSB +: BANK_W];
  assign unused_off = ^addr_i[OFF_W-1:0];

  // hashing mixes tag bits into the bank select only; word address is unchanged,
  // so (bank, word) stays unique because the tag bits remain in the word address
  assign bank_o  = (mode_i == bank_ilv_pkg::MAP_XOR) ? (low_bits ^ tag_bits) : low_bits;
  assign waddr_o = addr_i[ADDR_W-1:OFF_W+BANK_W];
endmodule

// File: rtl/bank_timer.sv
module bank_timer #(
  parameter int unsigned RECOVERY = 3,
  localparam int unsigned CNT_W   = $clog2(RECOVERY) + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (acc_i)         cnt_q <= CNT_W'(RECOVERY - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);

  assert_no_busy_accept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |-> (cnt_q == '0));

  assert_countdown_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/bank_ram.sv
module bank_ram #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[idx_i] <= wdata_i;
      else      rdata_q      <= mem_q[idx_i];
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/bank_interleave_ctrl.sv
module bank_interleave_ctrl #(
  parameter int unsigned ADDR_W     = 28,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned RECOVERY   = 3,
  parameter int unsigned BANK_DEPTH = 64,
  parameter int unsigned HASH_LSB   = 12,
  parameter int unsigned CNT_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xor_mode_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [CNT_W-1:0]  conflict_cnt_o
);
  localparam int unsigned WORD_BYTES = DATA_W / 8;
  localparam int unsigned OFF_W      = $clog2(WORD_BYTES);
  localparam int unsigned BANK_W     = $clog2(NUM_BANKS);
  localparam int unsigned WADDR_W    = ADDR_W - OFF_W - BANK_W;
  localparam int unsigned IDX_W      = $clog2(BANK_DEPTH);

  logic [BANK_W-1:0]    tgt_bank;
  logic [WADDR_W-1:0]   tgt_waddr;
  logic [NUM_BANKS-1:0] busy, acc;
  logic [DATA_W-1:0]    rdata_b [NUM_BANKS];
  logic                 fire;
  logic                 rd_pend_q;
  logic [BANK_W-1:0]    rd_bank_q;
  logic [CNT_W-1:0]     conf_q;
  logic                 unused_hi;

  bank_addr_map #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .NUM_BANKS(NUM_BANKS), .HASH_LSB(HASH_LSB)
  ) u_map (
    .addr_i  (req_addr_i),
    .mode_i  (bank_ilv_pkg::map_mode_e'(xor_mode_i)),
    .bank_o  (tgt_bank),
    .waddr_o (tgt_waddr)
  );

  assign unused_hi   = ^tgt_waddr[WADDR_W-1:IDX_W];
  assign req_ready_o = !busy[tgt_bank];
  assign fire        = req_valid_i && req_ready_o;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign acc[b] = fire && (tgt_bank == BANK_W'(b));

    bank_timer #(.RECOVERY(RECOVERY)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .acc_i  (acc[b]),
      .busy_o (busy[b])
    );

    bank_ram #(.DEPTH(BANK_DEPTH), .DATA_W(DATA_W)) u_ram (
      .clk_i   (clk_i),
      .en_i    (acc[b]),
      .we_i    (req_we_i),
      .idx_i   (tgt_waddr[IDX_W-1:0]),
      .wdata_i (req_wdata_i),
      .rdata_o (rdata_b[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      rd_bank_q <= '0;
      conf_q    <= '0;
    end else begin
      rd_pend_q <= fire && !req_we_i;
      if (fire) rd_bank_q <= tgt_bank;
      if (req_valid_i && !req_ready_o) conf_q <= conf_q + CNT_W'(1);
    end
  end

  assign rsp_valid_o    = rd_pend_q;
  assign rsp_rdata_o    = rdata_b[rd_bank_q];
  assign conflict_cnt_o = conf_q;

  assert_single_bank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(acc));

  assert_stall_counted_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o) |=> (conflict_cnt_o == $past(conflict_cnt_o) + CNT_W'(1)));

  assert_read_rsp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !req_we_i) |=> rsp_valid_o);

  assert_no_spurious_rsp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o && !req_we_i) |=> !rsp_valid_o);
endmodule

// File: tb/bank_interleave_ctrl_tb.sv
module bank_interleave_ctrl_tb_top;
  localparam int REC = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xor_mode_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_we_i = 1'b0;
  logic [27:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic [15:0] conflict_cnt_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk_i = ~clk_i;

  bank_interleave_ctrl dut_i (
    .clk_i, .rst_ni, .xor_mode_i, .req_valid_i, .req_ready_o, .req_we_i,
    .req_addr_i, .req_wdata_i, .rsp_valid_o, .rsp_rdata_o, .conflict_cnt_o
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic we, input logic [27:0] a, input logic [31:0] d,
                        output int stalls);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_we_i = we; req_addr_i = a; req_wdata_i = d;
    stalls = 0;
    #1;
    while (!req_ready_o) begin
      stalls++;
      @(negedge clk_i);
      #1;
    end
    @(posedge clk_i);
    #1 req_valid_i = 1'b0;
  endtask

  task automatic do_read(input logic [27:0] a, input logic [31:0] exp, input string tag);
    int s;
    do_req(1'b0, a, '0, s);
    @(negedge clk_i);
    check(rsp_valid_o === 1'b1, {tag, " R7 rsp_valid"}, rsp_valid_o, 1);
    check(rsp_rdata_o === exp, {tag, " data"}, rsp_rdata_o, exp);
    @(negedge clk_i);
    check(rsp_valid_o === 1'b0, {tag, " R7 pulse width"}, rsp_valid_o, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check(rsp_valid_o === 1'b0, "R1 rsp_valid", rsp_valid_o, 0);
    check(conflict_cnt_o === 16'd0, "R1 conflict count", conflict_cnt_o, 0);
    for (int b = 0; b < 4; b++) begin
      req_addr_i = 28'(b * 4);
      #1;
      check(req_ready_o === 1'b1, "R1 ready per bank", req_ready_o, 1);
    end
  endtask

  task automatic t_recovery();
    int s;
    logic [15:0] c0;
    idle(4);
    c0 = conflict_cnt_o;
    do_req(1'b1, 28'h28, 32'h1111_0000, s);
    do_req(1'b1, 28'h1A35C7B, 32'hCAFE_0001, s);
    check(s == REC - 1, "R3 R2 same bank 2 stall", s, REC - 1);
    idle(1);
    check(conflict_cnt_o == c0 + 16'(REC - 1), "R4 conflict delta", conflict_cnt_o, c0 + REC - 1);
    idle(4);
    do_req(1'b1, 28'h24, 32'h2222_0000, s);
    do_req(1'b1, 28'h30, 32'h3333_0000, s);
    check(s == 0, "R3 other bank no stall", s, 0);
    idle(4);
    // word 0x1A35C7 aliases word 0x07 in bank 2; byte offsets ignored
    do_read(28'h079, 32'hCAFE_0001, "R2 alias read");
    do_read(28'h1A35C78, 32'hCAFE_0001, "R2 byte offset read");
    do_req(1'b1, 28'h40, 32'h4444_0000, s);
    @(negedge clk_i);
    check(rsp_valid_o === 1'b0, "R7 write silent", rsp_valid_o, 0);
  endtask

  task automatic t_stream(input logic xm, input int stride, input int exp_stall, input string tag);
    int s;
    idle(4);
    xor_mode_i = xm;
    for (int i = 0; i < 8; i++) begin
      do_req(1'b1, 28'h200 + 28'(i * stride), 32'hA000_0000 + 32'(i), s);
      if (i > 0) check(s == exp_stall, tag, s, exp_stall);
    end
    idle(4);
    do_read(28'h200 + 28'(7 * stride), 32'hA000_0007, {tag, " readback"});
    xor_mode_i = 1'b0;
  endtask

  task automatic t_xor_data();
    int s;
    idle(4);
    xor_mode_i = 1'b1;
    for (int i = 0; i < 4; i++) do_req(1'b1, 28'h3000 + 28'(i * 4), 32'hB000_0000 + 32'(i), s);
    idle(4);
    for (int i = 0; i < 4; i++) do_read(28'h3000 + 28'(i * 4), 32'hB000_0000 + 32'(i), "R9 xor data");
    xor_mode_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_recovery();
    t_stream(1'b0, 4, 0, "R5 stride1");
    t_stream(1'b0, 16, REC - 1, "R6 stride4 plain");
    t_stream(1'b0, 4096, REC - 1, "R8 stride4096 plain");
    t_stream(1'b1, 4096, 0, "R8 stride4096 xor");
    t_xor_data();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule